// File: doc/BRIEF.md
# Page-Buffered Byte Programmer

This block gathers the data bytes of one page-program transaction and commits them to a small byte array in a single timed programming cycle. A load strobe gives the starting byte address. Each following byte strobe stores one byte into a staging register set that is one page wide. After each byte the in-page offset steps forward, while the page number stays fixed. An end-of-transfer strobe then starts the commit, provided at least one byte was staged.

During the commit a busy flag stays high for a fixed number of clock cycles, set by a parameter. In the last busy cycle every staged location is copied into the array at once. Locations of the page that received no byte keep their previous contents. While busy is high, every control input is ignored. A combinational read port exposes the array contents for inspection.

Top module: `pgwr_page_buffer`

## Requirements
- R1: After reset, busy_o is low and every array location reads the erased value 8'hFF.
- R2: A load accepted while idle takes the page number from the upper address bits and the in-page offset from the low 3 bits. It also empties the set of staged locations.
- R3: Each accepted byte is staged at the current offset. The offset then increases by one in its low 3 bits only, going from 7 back to 0 of the same page, and the page number never changes.
- R4: When more than 8 bytes arrive before the end strobe, a later byte that lands on an already staged offset replaces the earlier one, so the last byte at each offset is the one committed.
- R5: An end strobe accepted while idle with at least one staged byte raises busy_o on the next clock edge. busy_o then stays high for exactly BUSY_CYCLES consecutive cycles.
- R6: The array is unchanged until the last busy cycle. In that cycle every staged location of the page is written at once. Unstaged locations of the page keep their old contents. busy_o falls on the edge after this update.
- R7: An end strobe with no staged byte starts no programming cycle: busy_o stays low and the array is unchanged.
- R8: While busy_o is high, load, byte and end strobes have no effect. After the cycle ends, no bytes are staged, and the offset and page are those left by the last accepted byte.
- R9: When strobes coincide in an idle cycle, end takes precedence over load, and load over byte. The losing strobes are dropped.
- R10: rd_data_o shows the array byte at rd_addr_i combinationally, in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load starting byte address |
| load_addr_i | input | ADDR_W | Starting byte address |
| byte_stb_i | input | 1 | Byte strobe |
| byte_i | input | DATA_W | Byte to stage |
| stop_i | input | 1 | End of transfer; starts commit |
| busy_o | output | 1 | Programming cycle in progress |
| rd_addr_i | input | ADDR_W | Inspection read address |
| rd_data_o | output | DATA_W | Array byte at rd_addr_i |

## Verification
The bench sweeps every page, using a range of starting offsets and transfer lengths that cross the 7-to-0 wrap and exceed eight bytes. After each transfer it compares the whole page with an arithmetic model. A design that carried the offset into the page number would corrupt the neighbouring page. A design that kept the first byte instead of the last would leave stale data at the reused offsets. In every busy cycle the bench also reads one staged location, which catches a commit that lands early, late, or after busy has already dropped. Strobes sent during busy, a stop with nothing staged, and coincident load and byte strobes are each checked at the read port and at busy_o. These checks expose a design that accepts input while busy or that keeps a stale staging mask.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

   // One decoded action per idle cycle, in priority order.
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_STOP = 2'd1,
      OP_LOAD = 2'd2,
      OP_BYTE = 2'd3
   } pgwr_op_e;

   localparam int PGWR_ERASED = 8'hFF;

endpackage

// File: rtl/pgwr_pointer.sv
module pgwr_pointer #(
   parameter int ADDR_W    = 8,
   parameter int PAGE_BITS = 3,
   localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [PAGE_W-1:0]    page_o,
   output logic [PAGE_BITS-1:0] off_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_o <= '0;
         off_o  <= '0;
      end else if (load) begin
         page_o <= addr_i[ADDR_W-1:PAGE_BITS];
         off_o  <= addr_i[PAGE_BITS-1:0];
      end else if (step) begin
         off_o  <= off_o + 1'b1;   // natural wrap inside the page
      end
   end

endmodule

// File: rtl/pgwr_stage.sv
module pgwr_stage #(
   parameter int PAGE_BITS = 3,
   parameter int DATA_W    = 8,
   localparam int SLOTS    = 1 << PAGE_BITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    wr,
   input  logic [PAGE_BITS-1:0]    off,
   input  logic [DATA_W-1:0]       data,
   output logic [SLOTS*DATA_W-1:0] slots_o,
   output logic [SLOTS-1:0]        mask_o
);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = wr && (off == PAGE_BITS'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slots_o[s*DATA_W +: DATA_W] <= '0;
            mask_o[s]                   <= 1'b0;
         end else if (clear) begin
            mask_o[s] <= 1'b0;
         end else if (hit) begin
            slots_o[s*DATA_W +: DATA_W] <= data;
            mask_o[s]                   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
   parameter int BUSY_CYCLES = 500,
   localparam int CNT_W      = (BUSY_CYCLES > 2) ? $clog2(BUSY_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy_o,
   output logic commit_o
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt    <= '0;
      end else if (go) begin
         busy_o <= 1'b1;
         cnt    <= CNT_W'(BUSY_CYCLES - 1);
      end else if (busy_o) begin
         if (cnt == '0) busy_o <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   // Update lands in the last busy cycle; busy falls one edge later.
   assign commit_o = busy_o && (cnt == CNT_W'(1));

endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_BITS   = 3,
   parameter int DATA_W      = 8,
   parameter bit RESET_CLEAR = 1'b1,
   localparam int SLOTS      = 1 << PAGE_BITS,
   localparam int PAGE_W     = ADDR_W - PAGE_BITS,
   localparam int DEPTH      = 1 << ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [PAGE_W-1:0]       page,
   input  logic [SLOTS*DATA_W-1:0] slots,
   input  logic [SLOTS-1:0]        mask,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [DATA_W-1:0]       rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   if (RESET_CLEAR) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= DATA_W'(pgwr_pkg::PGWR_ERASED);
         end else if (commit) begin
            for (int s = 0; s < SLOTS; s++)
               if (mask[s]) mem[{page, PAGE_BITS'(s)}] <= slots[s*DATA_W +: DATA_W];
         end
      end
   end else begin : g_keep
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (commit) begin
            for (int s = 0; s < SLOTS; s++)
               if (mask[s]) mem[{page, PAGE_BITS'(s)}] <= slots[s*DATA_W +: DATA_W];
         end
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pgwr_page_buffer.sv
module pgwr_page_buffer #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_BITS   = 3,
   parameter int DATA_W      = 8,
   parameter int BUSY_CYCLES = 500,
   parameter bit RESET_CLEAR = 1'b1,
   localparam int SLOTS      = 1 << PAGE_BITS,
   localparam int PAGE_W     = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              byte_stb_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   output logic              busy_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   import pgwr_pkg::*;

   if (BUSY_CYCLES < 2 || PAGE_BITS < 1 || ADDR_W <= PAGE_BITS || DATA_W < 1) begin : g_bad_cfg
      initial $error("pgwr_page_buffer: illegal parameter set");
   end

   pgwr_op_e                op;
   logic                    go;
   logic                    commit;
   logic [PAGE_W-1:0]       page;
   logic [PAGE_BITS-1:0]    off;
   logic [SLOTS*DATA_W-1:0] slots;
   logic [SLOTS-1:0]        load_mask;

   always_comb begin
      op = OP_IDLE;
      if (!busy_o) begin
         if (stop_i)          op = OP_STOP;
         else if (load_i)     op = OP_LOAD;
         else if (byte_stb_i) op = OP_BYTE;
      end
   end

   assign go = (op == OP_STOP) && (|load_mask);

   pgwr_pointer #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) ptr_i (
      .clk(clk), .rst_n(rst_n),
      .load(op == OP_LOAD), .step(op == OP_BYTE),
      .addr_i(load_addr_i), .page_o(page), .off_o(off)
   );

   pgwr_stage #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) stage_i (
      .clk(clk), .rst_n(rst_n),
      .clear((op == OP_LOAD) || commit), .wr(op == OP_BYTE),
      .off(off), .data(byte_i), .slots_o(slots), .mask_o(load_mask)
   );

   pgwr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .go(go), .busy_o(busy_o), .commit_o(commit)
   );

   pgwr_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W),
                .RESET_CLEAR(RESET_CLEAR)) array_i (
      .clk(clk), .rst_n(rst_n), .commit(commit), .page(page),
      .slots(slots), .mask(load_mask), .rd_addr(rd_addr_i), .rd_data(rd_data_o)
   );

endmodule

// File: rtl/pgwr_checker.sv
module pgwr_checker #(
   parameter int PAGE_BITS   = 3,
   parameter int PAGE_W      = 5,
   parameter int BUSY_CYCLES = 500,
   localparam int SLOTS      = 1 << PAGE_BITS
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 load_i,
   input logic                 byte_stb_i,
   input logic                 stop_i,
   input logic                 busy,
   input logic                 commit,
   input logic [SLOTS-1:0]     mask,
   input logic [PAGE_BITS-1:0] off,
   input logic [PAGE_W-1:0]    page
);

   int busy_run;
   always_ff @(posedge clk) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R5: busy lasts exactly BUSY_CYCLES cycles
   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == BUSY_CYCLES));

   // R7: end strobe with nothing staged keeps busy low
   p_quiet_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !busy && (mask == '0)) |=> !busy);

   // R8: pointer frozen while busy
   p_hold_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(off) && $stable(page)));

   // R8: staged set frozen while busy, except the commit clear
   p_hold_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !commit) |=> $stable(mask));

   // R3: an accepted byte advances the offset by one, page kept
   p_wrap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !stop_i && !load_i && byte_stb_i) |=>
         ((off == PAGE_BITS'($past(off) + 1'b1)) && $stable(page)));

   // R6: after the update busy holds one more cycle, then drops, staging empty
   p_commit_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (busy && (mask == '0)) ##1 !busy);

endmodule

bind pgwr_page_buffer pgwr_checker #(
   .PAGE_BITS(PAGE_BITS), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)
) chk_i (
   .clk(clk), .rst_n(rst_n), .load_i(load_i), .byte_stb_i(byte_stb_i),
   .stop_i(stop_i), .busy(busy_o), .commit(commit), .mask(load_mask),
   .off(off), .page(page)
);

// File: tb/pgwr_page_buffer_tb.sv
module pgwr_page_buffer_tb_top;

   localparam int CLK_P  = 10;
   localparam int AW     = 6;
   localparam int BUSY   = 5;
   localparam int DEPTH  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [AW-1:0] load_addr_i = '0;
   logic          byte_stb_i = 1'b0;
   logic [7:0]    byte_i = '0;
   logic          stop_i = 1'b0;
   logic          busy_o;
   logic [AW-1:0] rd_addr_i = '0;
   logic [7:0]    rd_data_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   pgwr_page_buffer #(.ADDR_W(AW), .PAGE_BITS(3), .DATA_W(8), .BUSY_CYCLES(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
      .byte_stb_i(byte_stb_i), .byte_i(byte_i), .stop_i(stop_i), .busy_o(busy_o),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   // Bench model of the requirements
   logic [7:0] exp_mem [DEPTH];
   logic [7:0] m_buf [8];
   bit         m_msk [8];
   int         m_page, m_off;

   function automatic void m_load(int a);
      m_page = a / 8;
      m_off  = a % 8;
      for (int s = 0; s < 8; s++) m_msk[s] = 1'b0;
   endfunction

   function automatic void m_byte(logic [7:0] d);
      m_buf[m_off] = d;
      m_msk[m_off] = 1'b1;
      m_off = (m_off + 1) % 8;
   endfunction

   function automatic void m_commit();
      for (int s = 0; s < 8; s++) begin
         if (m_msk[s]) exp_mem[m_page*8 + s] = m_buf[s];
         m_msk[s] = 1'b0;
      end
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // One cycle of strobes; returns just after the edge that samples them.
   task automatic pulse(input bit ld, input int a, input bit stb, input logic [7:0] d, input bit sp);
      @(negedge clk);
      load_i = ld; load_addr_i = AW'(a); byte_stb_i = stb; byte_i = d; stop_i = sp;
      @(posedge clk);
      #1;
      load_i = 0; byte_stb_i = 0; stop_i = 0;
   endtask

   task automatic check_page(input int p, input string req);
      for (int s = 0; s < 8; s++) begin
         rd_addr_i = AW'(p*8 + s);
         #1;
         chk(rd_data_o === exp_mem[p*8 + s], req, rd_data_o, exp_mem[p*8 + s]);
      end
   endtask

   // Call right after a stop pulse; watches busy and one staged location.
   task automatic run_busy(input int probe, input logic [7:0] newv);
      int k = 0;
      logic [7:0] oldv = exp_mem[probe];
      @(negedge clk);
      while (busy_o && k < 1000) begin
         k++;
         rd_addr_i = AW'(probe);
         #1;
         chk(rd_data_o === ((k == BUSY) ? newv : oldv), "R6 commit timing",
             rd_data_o, (k == BUSY) ? newv : oldv);
         @(negedge clk);
      end
      chk(k == BUSY, "R5 busy length", k, BUSY);
      m_commit();
   endtask

   task automatic check_idle(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(busy_o === 1'b0, req, busy_o, 0);
      end
   endtask

   task automatic last_probe(output int addr, output logic [7:0] v);
      int slot = (m_off + 7) % 8;
      addr = m_page*8 + slot;
      v = m_buf[slot];
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int pa;
      logic [7:0] pv;
      for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
      m_load(0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state, R10 combinational read
      @(negedge clk);
      chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
      for (int p = 0; p < 8; p++) check_page(p, "R1 R10 erased array");

      // R7: load then stop with nothing staged
      pulse(1, 3*8 + 2, 0, 0, 0);
      m_load(3*8 + 2);
      pulse(0, 0, 0, 0, 1);
      check_idle(3, "R7 empty stop no busy");
      check_page(3, "R7 array untouched");

      // Sweep all pages: R2 R3 R4 R5 R6
      for (int p = 0; p < 8; p++) begin
         int o0  = (p * 5) % 8;
         int len = (p * 3) % 12 + 1 + ((p == 7) ? 7 : 0);
         pulse(1, p*8 + o0, 0, 0, 0);
         m_load(p*8 + o0);
         for (int i = 0; i < len; i++) begin
            logic [7:0] d = 8'(p*37 + i*11 + 1);
            pulse(0, 0, 1, d, 0);
            m_byte(d);
         end
         last_probe(pa, pv);
         pulse(0, 0, 0, 0, 1);
         run_busy(pa, pv);
         check_page(p, "R2 R3 R4 page contents");
         if (p > 0) check_page(p - 1, "R3 neighbour page intact");
      end

      // R9: load and byte together: byte dropped; stop over byte
      pulse(1, 2*8 + 3, 1, 8'h55, 0);
      m_load(2*8 + 3);
      pulse(0, 0, 1, 8'hA1, 0);
      m_byte(8'hA1);
      last_probe(pa, pv);
      pulse(0, 0, 1, 8'h77, 1);          // stop wins, byte dropped
      run_busy(pa, pv);
      check_page(2, "R9 strobe priority");

      // R8: strobes while busy have no effect
      pulse(1, 5*8 + 6, 0, 0, 0);
      m_load(5*8 + 6);
      pulse(0, 0, 1, 8'h11, 0); m_byte(8'h11);
      pulse(0, 0, 1, 8'h22, 0); m_byte(8'h22);
      pulse(0, 0, 0, 0, 1);
      pulse(1, 1*8, 0, 0, 0);
      pulse(0, 0, 1, 8'h99, 0);
      pulse(0, 0, 1, 8'h98, 0);
      pulse(0, 0, 0, 0, 1);
      while (busy_o) @(negedge clk);
      m_commit();
      check_page(1, "R8 load while busy ignored");
      check_page(5, "R8 bytes while busy ignored");
      pulse(0, 0, 0, 0, 1);
      check_idle(3, "R8 staging empty after commit");
      pulse(0, 0, 1, 8'h33, 0); m_byte(8'h33);   // continues at offset 0 of page 5
      last_probe(pa, pv);
      chk(pa == 5*8, "R8 pointer kept", pa, 5*8);
      pulse(0, 0, 0, 0, 1);
      run_busy(pa, pv);
      check_page(5, "R8 R3 pointer continues after busy");
      check_page(1, "R8 other page unchanged");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule